// File: doc/BRIEF.md
# Serial PCM Port with Companding-Format Conversion

This block connects an internal 8-bit sign-magnitude companded sample to the serial PCM pins of a codec. On the transmit side it takes the sample at each frame sync and converts it to the selected line format. The format is one of A-law with alternate-bit inversion, plain sign-magnitude, or mu-law with all-zero suppression. It then shifts the byte out MSB first. On the receive side it collects eight serial bits, converts them back to sign-magnitude and presents them with a one-cycle strobe.

All port timing comes from data-clock, enable and frame-sync signals that are sampled in the system clock domain. A power-down input holds the port idle and releases the transmit pin. After wake-up the transmit pin stays released for two whole frames before it drives again. A build parameter lets the receive side reuse the transmit data clock.

Top module: `pcm_serial_port`

## Requirements
- R1: With `line_fmt` = 1 (sign-magnitude), the line byte equals the sample in both directions. The value 3 behaves like value 1.
- R2: With `line_fmt` = 2 (mu-law), the transmitted byte keeps the sample's MSB and inverts the seven lower bits. Examples: 1111 1111 goes out as 1000 0000, 1000 0000 as 1111 1111, and 0000 0000 as 0111 1111.
- R3: In mu-law mode, a converted result of 0000 0000 goes out as 0000 0010 instead. So sample 0111 1111 goes out as 0000 0010.
- R4: With `line_fmt` = 0 (A-law), the transmitted byte keeps the MSB and inverts every second bit counted from the MSB, i.e. XOR with 0101 0101. No zero suppression is applied. Examples: 1111 1111 goes out as 1010 1010, 1000 0000 as 1101 0101, 0000 0000 as 0101 0101, and 0111 1111 as 0010 1010.
- R5: The sample is loaded at a rising edge of `fsync`. On each of the next eight rising edges of `tx_dclk` seen while `tx_en` is high, the next bit is presented on `pcm_tx`, MSB first. `pcm_tx_oe` is high only while `tx_en` is high.
- R6: `pcm_rx` is captured on falling edges of the receive data clock while `rx_en` is high. A rising `fsync` restarts the bit count. After the eighth bit, `rx_sample` holds the decoded byte and `rx_valid` pulses.
- R7: Receive decoding applies the inverse of the selected mapping. In mu-law mode, 0000 0010 decodes to 0111 1101 and 0000 0000 decodes to 0111 1111. In A-law mode, 1010 1010 decodes to 1111 1111.
- R8: While `pd_n` is low, `pcm_tx_oe` is low, no `rx_valid` is produced, and data-clock edges are ignored.
- R9: After `pd_n` rises (and after reset), `pcm_tx_oe` stays low through the frames started by the first two `fsync` pulses. Driving resumes from the third frame on.
- R10: `rx_valid` is never high on two consecutive clock cycles.
- R11: Out of reset, `pcm_tx_oe` and `rx_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Power-down, active low |
| fsync | input | 1 | Frame sync; its rising edge starts a frame |
| line_fmt | input | 2 | Line format: 0 A-law, 1 sign-magnitude, 2 mu-law, 3 as 1 |
| tx_dclk | input | 1 | Transmit data clock (sampled by clk) |
| tx_en | input | 1 | Transmit enable |
| tx_sample | input | 8 | Sign-magnitude sample to transmit |
| pcm_tx | output | 1 | Serial transmit data, released to high impedance when not driving |
| pcm_tx_oe | output | 1 | High while pcm_tx is driven |
| rx_dclk | input | 1 | Receive data clock (unused when shared clock selected) |
| rx_en | input | 1 | Receive enable |
| pcm_rx | input | 1 | Serial receive data |
| rx_sample | output | 8 | Decoded sign-magnitude receive sample |
| rx_valid | output | 1 | One-cycle strobe when rx_sample updates |

## Verification
The assertions assume that data clocks, enables and frame sync are already synchronous to `clk` and change far more slowly than it. They also assume that a frame sync never coincides with a data-clock edge. The stimulus meets this as follows. Every input changes on a falling system-clock edge. Each data-clock level is held for four system cycles. The frame-sync pulse lasts one cycle and sits before the first data-clock rise. Each frame carries exactly eight data-clock periods.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    FMT_ALAW = 2'd0,
    FMT_SMAG = 2'd1,
    FMT_ULAW = 2'd2,
    FMT_RSVD = 2'd3
  } line_fmt_e;

  localparam logic [BYTE_W-1:0] ALAW_FLIP  = 8'h55;
  localparam logic [BYTE_W-1:0] ULAW_FLIP  = 8'h7F;
  localparam logic [BYTE_W-1:0] ULAW_SUBST = 8'h02;

  // sign-magnitude to line code
  function automatic logic [BYTE_W-1:0] to_line(input logic [BYTE_W-1:0] smag,
                                                input line_fmt_e fmt);
    logic [BYTE_W-1:0] r;
    case (fmt)
      FMT_ALAW: r = smag ^ ALAW_FLIP;
      FMT_ULAW: begin
        r = smag ^ ULAW_FLIP;
        if (r == '0) r = ULAW_SUBST;
      end
      default:  r = smag;
    endcase
    return r;
  endfunction

  // line code to sign-magnitude
  function automatic logic [BYTE_W-1:0] from_line(input logic [BYTE_W-1:0] code,
                                                  input line_fmt_e fmt);
    logic [BYTE_W-1:0] r;
    case (fmt)
      FMT_ALAW: r = code ^ ALAW_FLIP;
      FMT_ULAW: r = code ^ ULAW_FLIP;
      default:  r = code;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pcm_edge_det.sv
module pcm_edge_det #(
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic hit
);

  logic prev_q;
  logic prev_d;

  always_comb prev_d = sig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  generate
    if (RISING) begin : g_rise
      assign hit = sig & ~prev_q;
    end else begin : g_fall
      assign hit = ~sig & prev_q;
    end
  endgenerate

endmodule

// File: rtl/pcm_wake_gate.sv
module pcm_wake_gate #(
  parameter int WAKE_FRAMES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  input  logic frame_start,
  output logic ready
);

  localparam int CW = (WAKE_FRAMES < 1) ? 1 : $clog2(WAKE_FRAMES + 1);
  localparam logic [CW-1:0] LAST = CW'(WAKE_FRAMES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          rdy_q, rdy_d;

  always_comb begin
    cnt_d = cnt_q;
    rdy_d = rdy_q;
    if (idle) begin
      cnt_d = '0;
      rdy_d = 1'b0;
    end else if (frame_start) begin
      if (cnt_q == LAST) rdy_d = 1'b1;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end

  assign ready = rdy_q;

  // R9: power-down always drops the transmit permission
  a_r9_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> !ready);

  // R9: permission only appears on a frame boundary
  a_r9_ready_on_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(frame_start));

endmodule

// File: rtl/pcm_tx_shift.sv
module pcm_tx_shift
  import pcm_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle,
  input  logic              load,
  input  line_fmt_e         fmt,
  input  logic [BYTE_W-1:0] sample,
  input  logic              shift,
  input  logic              en,
  input  logic              ready,
  output logic              tx_bit,
  output logic              oe
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] DONE = CNT_W'(BYTE_W);

  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              bit_q, bit_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    bit_d = bit_q;
    if (idle) begin
      sh_d  = '0;
      cnt_d = DONE;
      bit_d = 1'b0;
    end else if (load) begin
      sh_d  = to_line(sample, fmt);
      cnt_d = '0;
    end else if (shift && en && (cnt_q < DONE)) begin
      bit_d = sh_q[BYTE_W-1];
      sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= DONE;
      bit_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      bit_q <= bit_d;
    end
  end

  assign tx_bit = bit_q;
  assign oe     = ready & en & ~idle;

  // R5: never more than one byte of shifts per frame
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= DONE);

  // R8: clocks are ignored while powered down
  a_r8_tx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> (cnt_q == DONE && !bit_q));

endmodule

// File: rtl/pcm_rx_shift.sv
module pcm_rx_shift
  import pcm_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle,
  input  logic              frame_start,
  input  logic              cap,
  input  logic              din,
  input  line_fmt_e         fmt,
  output logic [BYTE_W-1:0] sample,
  output logic              valid
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] dat_q, dat_d;
  logic              vld_q, vld_d;
  logic [BYTE_W-1:0] full;

  always_comb full = {sh_q[BYTE_W-2:0], din};

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    dat_d = dat_q;
    vld_d = 1'b0;
    if (idle) begin
      sh_d  = '0;
      cnt_d = '0;
    end else if (frame_start) begin
      cnt_d = '0;
    end else if (cap) begin
      sh_d = full;
      if (cnt_q == LAST) begin
        cnt_d = '0;
        dat_d = from_line(full, fmt);
        vld_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      dat_q <= '0;
      vld_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      dat_q <= dat_d;
      vld_q <= vld_d;
    end
  end

  assign sample = dat_q;
  assign valid  = vld_q;

  // R10: strobe is a single cycle
  a_r10_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  // R8: no strobe follows a powered-down cycle
  a_r8_no_rx_in_pd: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> !valid);

  // R6: a strobe always follows a capture edge
  a_r6_valid_after_cap: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $past(cap));

endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
  import pcm_port_pkg::*;
#(
  parameter bit SHARED_DCLK = 1'b0,
  parameter int WAKE_FRAMES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pd_n,
  input  logic       fsync,
  input  logic [1:0] line_fmt,
  input  logic       tx_dclk,
  input  logic       tx_en,
  input  logic [7:0] tx_sample,
  output logic       pcm_tx,
  output logic       pcm_tx_oe,
  input  logic       rx_dclk,
  input  logic       rx_en,
  input  logic       pcm_rx,
  output logic [7:0] rx_sample,
  output logic       rx_valid
);

  logic      idle;
  logic      rx_clk_sel;
  logic      fs_rise, txc_rise, rxc_fall;
  logic      tx_ready;
  logic      tx_bit;
  line_fmt_e fmt;

  assign idle = ~pd_n;
  assign fmt  = line_fmt_e'(line_fmt);

  generate
    if (SHARED_DCLK) begin : g_shared_clk
      assign rx_clk_sel = tx_dclk;
    end else begin : g_split_clk
      assign rx_clk_sel = rx_dclk;
    end
  endgenerate

  pcm_edge_det #(.RISING(1'b1)) u_fs_edge (
    .clk(clk), .rst_n(rst_n), .sig(fsync), .hit(fs_rise));

  pcm_edge_det #(.RISING(1'b1)) u_txc_edge (
    .clk(clk), .rst_n(rst_n), .sig(tx_dclk), .hit(txc_rise));

  pcm_edge_det #(.RISING(1'b0)) u_rxc_edge (
    .clk(clk), .rst_n(rst_n), .sig(rx_clk_sel), .hit(rxc_fall));

  pcm_wake_gate #(.WAKE_FRAMES(WAKE_FRAMES)) u_wake (
    .clk(clk), .rst_n(rst_n), .idle(idle),
    .frame_start(fs_rise), .ready(tx_ready));

  pcm_tx_shift u_tx (
    .clk(clk), .rst_n(rst_n), .idle(idle), .load(fs_rise),
    .fmt(fmt), .sample(tx_sample), .shift(txc_rise), .en(tx_en),
    .ready(tx_ready), .tx_bit(tx_bit), .oe(pcm_tx_oe));

  pcm_rx_shift u_rx (
    .clk(clk), .rst_n(rst_n), .idle(idle), .frame_start(fs_rise),
    .cap(rxc_fall & rx_en), .din(pcm_rx), .fmt(fmt),
    .sample(rx_sample), .valid(rx_valid));

  assign pcm_tx = pcm_tx_oe ? tx_bit : 1'bz;

  // R5: the pin is driven only under its enable
  a_r5_oe_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_tx_oe |-> tx_en);

  // R8: the pin is released during power-down
  a_r8_oe_off_pd: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |-> !pcm_tx_oe);

endmodule

// File: tb/sim_pcm_serial_port.sv
`timescale 1ns/1ps
module sim_pcm_serial_port;

  logic       clk = 1'b0;
  logic       rst_n, pd_n, fsync, tx_dclk, tx_en, rx_dclk, rx_en, pcm_rx;
  logic [1:0] line_fmt;
  logic [7:0] tx_sample;
  wire        pcm_tx;
  logic       pcm_tx_oe;
  logic [7:0] rx_sample;
  logic       rx_valid;

  int checks = 0;
  int errors = 0;
  int valid_seen = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  pcm_serial_port u0 (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .fsync(fsync),
    .line_fmt(line_fmt), .tx_dclk(tx_dclk), .tx_en(tx_en),
    .tx_sample(tx_sample), .pcm_tx(pcm_tx), .pcm_tx_oe(pcm_tx_oe),
    .rx_dclk(rx_dclk), .rx_en(rx_en), .pcm_rx(pcm_rx),
    .rx_sample(rx_sample), .rx_valid(rx_valid));

  task automatic chk(input bit ok, input string req,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] enc_exp(input logic [1:0] m, input logic [7:0] s);
    logic [7:0] r;
    r = s;
    if (m == 2'd0) begin
      for (int i = 0; i < 8; i++)
        if (i % 2 == 0) r[i] = ~s[i];
    end else if (m == 2'd2) begin
      r = {s[7], ~s[6:0]};
      if (r == 8'h00) r = 8'b0000_0010;
    end
    return r;
  endfunction

  function automatic logic [7:0] dec_exp(input logic [1:0] m, input logic [7:0] c);
    logic [7:0] r;
    r = c;
    if (m == 2'd0) begin
      for (int i = 0; i < 8; i++)
        if (i % 2 == 0) r[i] = ~c[i];
    end else if (m == 2'd2) begin
      r = {c[7], ~c[6:0]};
    end
    return r;
  endfunction

  // driver: one frame of eight bit periods on both directions
  task automatic frame(input logic [1:0] m, input logic [7:0] txs,
                       input logic [7:0] rxb, input bit exp_drive,
                       input bit exp_rx, input string tag);
    logic [7:0] got;
    bit oe_any, oe_all;
    int v0;
    got = '0; oe_any = 1'b0; oe_all = 1'b1;
    v0 = valid_seen;
    @(negedge clk);
    fsync = 1'b1; line_fmt = m; tx_sample = txs;
    @(negedge clk);
    fsync = 1'b0;
    if (exp_rx) begin
      exp_q.push_back(dec_exp(m, rxb));
      tag_q.push_back(tag);
    end
    for (int i = 0; i < 8; i++) begin
      tx_dclk = 1'b1; rx_dclk = 1'b1; pcm_rx = rxb[7-i];
      repeat (4) @(negedge clk);
      got[7-i] = pcm_tx;
      if (pcm_tx_oe) oe_any = 1'b1; else oe_all = 1'b0;
      tx_dclk = 1'b0; rx_dclk = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    if (exp_drive) begin
      chk(oe_all, {tag, " drive"}, {7'd0, oe_all}, 8'd1);
      chk(got == enc_exp(m, txs), {tag, " tx byte"}, got, enc_exp(m, txs));
    end else begin
      chk(!oe_any, {tag, " released"}, {7'd0, oe_any}, 8'd0);
    end
    if (!exp_rx)
      chk(valid_seen == v0, {tag, " no strobe"}, 8'(valid_seen - v0), 8'd0);
  endtask

  // monitor: pop and compare each received sample
  always @(negedge clk) begin
    if (rst_n === 1'b1 && rx_valid === 1'b1) begin
      valid_seen++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected strobe", rx_sample, 8'h00);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rx_sample == e, {t, " rx sample"}, rx_sample, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 8'h00, 8'h01);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pd_n = 1'b1; fsync = 1'b0; line_fmt = 2'd1;
    tx_dclk = 1'b0; rx_dclk = 1'b0; tx_en = 1'b1; rx_en = 1'b1;
    pcm_rx = 1'b0; tx_sample = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!pcm_tx_oe, "R11 oe after reset", {7'd0, pcm_tx_oe}, 8'd0);
    chk(!rx_valid, "R11 valid after reset", {7'd0, rx_valid}, 8'd0);

    // R9: two released frames after reset, receive still works (R1)
    frame(2'd1, 8'h11, 8'h3C, 1'b0, 1'b1, "R9 wake frame 1 / R1");
    frame(2'd1, 8'h22, 8'hC3, 1'b0, 1'b1, "R9 wake frame 2 / R1");

    // R2 / R3 mu-law reference points, R7 receive decode
    frame(2'd2, 8'hFF, 8'h02, 1'b1, 1'b1, "R2 mu +full / R7");
    frame(2'd2, 8'h80, 8'h00, 1'b1, 1'b1, "R2 mu +zero / R7");
    frame(2'd2, 8'h00, 8'hFF, 1'b1, 1'b1, "R2 mu -zero / R7");
    frame(2'd2, 8'h7F, 8'h80, 1'b1, 1'b1, "R3 mu suppress / R7");

    // R4 A-law reference points
    frame(2'd0, 8'hFF, 8'hAA, 1'b1, 1'b1, "R4 A +full / R7");
    frame(2'd0, 8'h80, 8'hD5, 1'b1, 1'b1, "R4 A +zero");
    frame(2'd0, 8'h00, 8'h55, 1'b1, 1'b1, "R4 A -zero");
    frame(2'd0, 8'h7F, 8'h2A, 1'b1, 1'b1, "R4 A -full");

    // R1 plain and reserved code
    frame(2'd1, 8'h5A, 8'h96, 1'b1, 1'b1, "R1 plain");
    frame(2'd3, 8'hC3, 8'h0F, 1'b1, 1'b1, "R1 reserved as plain");

    // R5 enable low releases the pin
    tx_en = 1'b0;
    frame(2'd1, 8'hA5, 8'h5A, 1'b0, 1'b1, "R5 enable low");
    tx_en = 1'b1;
    frame(2'd2, 8'h3B, 8'h6E, 1'b1, 1'b1, "R5 enable restored / R6");

    // R6 receive enable low: no capture in this frame
    rx_en = 1'b0;
    frame(2'd1, 8'h01, 8'hF0, 1'b1, 1'b0, "R6 rx enable low");
    rx_en = 1'b1;

    // R8 power-down, then R9 wake-up delay
    pd_n = 1'b0;
    frame(2'd2, 8'h44, 8'h12, 1'b0, 1'b0, "R8 power-down");
    pd_n = 1'b1;
    frame(2'd2, 8'h44, 8'h34, 1'b0, 1'b1, "R9 after pd frame 1");
    frame(2'd0, 8'h66, 8'h78, 1'b0, 1'b1, "R9 after pd frame 2");
    frame(2'd0, 8'h99, 8'h9A, 1'b1, 1'b1, "R9 after pd frame 3");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R6 pending samples", 8'(exp_q.size()), 8'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule